// File: doc/BRIEF.md
# Flash Read Multiplexer with Status and Erase Timer

This block is the read half of a parallel NOR flash model. For every read it picks one of four sources, chosen by the command mode that a separate write-side sequencer supplies. The sources are array bytes assembled to the access width, the identification words, a status byte whose bit 6 toggles on every read, and one entry of an external CFI query ROM.

The block owns the status byte and the erase busy timer. An erase start clears the status byte and loads the timer with a chip or sector duration, given in clock cycles. When the timer runs out, the block inverts status bit 7 and sends a one-cycle done pulse back to the sequencer. With that pulse it also sends a flag that tells the sequencer whether to go back to the bypass command cycle or to plain read mode.

Top module: `flash_read_port`

## Requirements
- R1: With mode 0 (read), mode 1 (erase unlock) or any code from 5 to 7, a read returns array bytes. `arr_bytes[7:0]` is the byte at the address and each higher lane is the next address. `acc_size` 0 gives 1 byte, 1 gives 2 bytes and 2 gives 4 bytes. With `big_endian` high the lowest address goes to the most significant byte. Unused upper bits are zero.
- R2: `rdata` changes on the clock edge that samples `rd_en` high, and it holds its value while `rd_en` is low.
- R3: In autoselect mode (mode 2) the word index is `addr[7:0]` shifted right by log2 of DEV_BYTES. Index 0 returns ID0, index 1 returns ID1 and index 2 returns 0.
- R4: In autoselect mode, index 0x0E returns ID2 and index 0x0F returns ID3. Either one falls back to the array word when that ID's low byte is 0xFF. Every other index returns the array word.
- R5: In status mode (mode 3) a read returns the current status byte, and bit 6 of the status is inverted on the same edge.
- R6: A `prog_go` pulse sets the status to 0x7F when `prog_msb` is 1, and to 0xFF when it is 0.
- R7: A `chip_erase_go` or `sector_erase_go` pulse clears the status to 0x00 and reloads the busy timer, even while an earlier erase is still counting.
- R8: `erase_done` goes high for one cycle exactly CHIP_CYCLES or SECTOR_CYCLES edges after the edge that sampled the most recent erase start. On that same edge status bit 7 is inverted, and `done_to_bypass` carries the value of `bypass`.
- R9: In CFI mode (mode 4), `cfi_index` carries the word index, and a read returns `cfi_byte` when the index is below CFI_DEPTH and 0 otherwise.
- R10: After reset, `rdata` is 0, the status is 0x00, and `erase_done` and `done_to_bypass` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset of the read |
| acc_size | input | 2 | Access width code: 0, 1 or 2 for 1, 2 or 4 bytes |
| big_endian | input | 1 | Byte order for multi-byte array reads |
| mode | input | 3 | Command mode from the sequencer |
| bypass | input | 1 | Bypass state of the sequencer |
| arr_bytes | input | 32 | Array bytes at addr to addr+3, lowest address in bits 7:0 |
| cfi_index | output | 8 | Word index presented to the CFI ROM |
| cfi_byte | input | 8 | CFI ROM entry at cfi_index |
| prog_go | input | 1 | Program pulse |
| prog_msb | input | 1 | Bit 7 of the programmed data |
| chip_erase_go | input | 1 | Chip erase start pulse |
| sector_erase_go | input | 1 | Sector erase start pulse |
| rdata | output | 32 | Registered read data |
| erase_done | output | 1 | One-cycle pulse when the erase timer expires |
| done_to_bypass | output | 1 | High with erase_done when bypass was set |

## Verification
The bench builds the block with DEV_BYTES=2, CHIP_CYCLES=20 and SECTOR_CYCLES=7. It also picks an ID3 whose low byte is 0xFF, so the fallback path can be seen. With these values, full sweeps of all 256 low address offsets in autoselect and CFI mode are cheap, and they cover the word scaling and the end of the table. The short timer durations let the bench count every edge up to expiry for a chip erase, a sector erase with reads during the busy time, and a restarted erase.

// File: rtl/flash_read_port_pkg.sv
package flash_read_port_pkg;
    localparam logic [2:0] MODE_READ    = 3'd0;
    localparam logic [2:0] MODE_UNLOCK  = 3'd1;
    localparam logic [2:0] MODE_AUTOSEL = 3'd2;
    localparam logic [2:0] MODE_STATUS  = 3'd3;
    localparam logic [2:0] MODE_CFI     = 3'd4;

    localparam logic [1:0] SIZE_1B = 2'd0;
    localparam logic [1:0] SIZE_2B = 2'd1;
    localparam logic [1:0] SIZE_4B = 2'd2;

    typedef struct packed {
        logic [7:0]  status;
        logic [31:0] rdata;
        logic        done;
        logic        done_byp;
    } port_state_t;

    typedef struct packed {
        logic busy;
        logic [31:0] cnt;
    } timer_state_t;
endpackage

// File: rtl/frp_lane_pack.sv
module frp_lane_pack
    import flash_read_port_pkg::*;
(
    input  logic [31:0] bytes_in,
    input  logic [1:0]  size,
    input  logic        big_endian,
    output logic [31:0] word
);
    localparam int LANES = 4;

    logic [LANES-1:0][7:0] lane;
    logic [LANES-1:0][7:0] le_word;
    logic [LANES-1:0][7:0] be2_word;
    logic [LANES-1:0][7:0] be4_word;

    assign lane = bytes_in;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign le_word[g]  = lane[g];
        assign be4_word[g] = lane[LANES-1-g];
        if (g < 2) begin : g_low
            assign be2_word[g] = lane[1-g];
        end else begin : g_high
            assign be2_word[g] = 8'h00;
        end
    end

    always_comb begin
        word = 32'h0;
        case (size)
            SIZE_1B: word = {24'h0, lane[0]};
            SIZE_2B: word = big_endian ? be2_word : {16'h0, le_word[1], le_word[0]};
            SIZE_4B: word = big_endian ? be4_word : le_word;
            default: word = {24'h0, lane[0]};
        endcase
    end
endmodule

// File: rtl/frp_id_select.sv
module frp_id_select #(
    parameter logic [15:0] ID0 = 16'h0001,
    parameter logic [15:0] ID1 = 16'h0000,
    parameter logic [15:0] ID2 = 16'h0000,
    parameter logic [15:0] ID3 = 16'h0000
) (
    input  logic [7:0]  idx,
    input  logic [31:0] arr_word,
    output logic [31:0] word
);
    localparam bit ID2_FALLS = (ID2[7:0] == 8'hFF);
    localparam bit ID3_FALLS = (ID3[7:0] == 8'hFF);

    always_comb begin
        case (idx)
            8'h00:   word = {16'h0, ID0};
            8'h01:   word = {16'h0, ID1};
            8'h02:   word = 32'h0;
            8'h0E:   word = ID2_FALLS ? arr_word : {16'h0, ID2};
            8'h0F:   word = ID3_FALLS ? arr_word : {16'h0, ID3};
            default: word = arr_word;
        endcase
    end
endmodule

// File: rtl/frp_erase_timer.sv
module frp_erase_timer
    import flash_read_port_pkg::*;
#(
    parameter int unsigned CHIP_CYCLES   = 625_000_000,
    parameter int unsigned SECTOR_CYCLES = 62_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_chip,
    input  logic start_sector,
    output logic expire
);
    timer_state_t q, d;

    always_comb begin
        d      = q;
        expire = 1'b0;
        if (start_chip) begin
            d.busy = 1'b1;
            d.cnt  = CHIP_CYCLES;
        end else if (start_sector) begin
            d.busy = 1'b1;
            d.cnt  = SECTOR_CYCLES;
        end else if (q.busy) begin
            if (q.cnt <= 32'd1) begin
                d.busy = 1'b0;
                d.cnt  = 32'd0;
                expire = 1'b1;
            end else begin
                d.cnt = q.cnt - 32'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/flash_read_port.sv
module flash_read_port
    import flash_read_port_pkg::*;
#(
    parameter int unsigned ADDR_W        = 16,
    parameter int unsigned DEV_BYTES     = 2,
    parameter logic [15:0] ID0           = 16'h0001,
    parameter logic [15:0] ID1           = 16'h227E,
    parameter logic [15:0] ID2           = 16'h2210,
    parameter logic [15:0] ID3           = 16'h2201,
    parameter int unsigned CFI_DEPTH     = 82,
    parameter int unsigned CHIP_CYCLES   = 625_000_000,
    parameter int unsigned SECTOR_CYCLES = 62_500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        acc_size,
    input  logic              big_endian,
    input  logic [2:0]        mode,
    input  logic              bypass,
    input  logic [31:0]       arr_bytes,
    output logic [7:0]        cfi_index,
    input  logic [7:0]        cfi_byte,
    input  logic              prog_go,
    input  logic              prog_msb,
    input  logic              chip_erase_go,
    input  logic              sector_erase_go,
    output logic [31:0]       rdata,
    output logic              erase_done,
    output logic              done_to_bypass
);
    localparam int unsigned IDX_SHIFT = (DEV_BYTES == 4) ? 2 : (DEV_BYTES == 2) ? 1 : 0;

    port_state_t q, d;
    logic [7:0]  word_idx;
    logic [31:0] arr_word;
    logic [31:0] id_word;
    logic        tmr_expire;
    logic [7:0]  status_now;

    assign word_idx   = addr[7:0] >> IDX_SHIFT;
    assign cfi_index  = word_idx;
    assign status_now = q.status;

    frp_lane_pack u_pack (
        .bytes_in   (arr_bytes),
        .size       (acc_size),
        .big_endian (big_endian),
        .word       (arr_word)
    );

    frp_id_select #(
        .ID0 (ID0), .ID1 (ID1), .ID2 (ID2), .ID3 (ID3)
    ) u_ids (
        .idx      (word_idx),
        .arr_word (arr_word),
        .word     (id_word)
    );

    frp_erase_timer #(
        .CHIP_CYCLES   (CHIP_CYCLES),
        .SECTOR_CYCLES (SECTOR_CYCLES)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_chip   (chip_erase_go),
        .start_sector (sector_erase_go),
        .expire       (tmr_expire)
    );

    always_comb begin
        d          = q;
        d.done     = tmr_expire;
        d.done_byp = tmr_expire & bypass;

        if (rd_en) begin
            case (mode)
                MODE_AUTOSEL: d.rdata = id_word;
                MODE_STATUS: begin
                    d.rdata  = {24'h0, q.status};
                    d.status = q.status ^ 8'h40;
                end
                MODE_CFI: d.rdata = (32'(word_idx) < CFI_DEPTH) ? {24'h0, cfi_byte} : 32'h0;
                default:  d.rdata = arr_word;
            endcase
        end

        if (tmr_expire)
            d.status = d.status ^ 8'h80;
        if (prog_go)
            d.status = prog_msb ? 8'h7F : 8'hFF;
        if (chip_erase_go || sector_erase_go)
            d.status = 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata          = q.rdata;
    assign erase_done     = q.done;
    assign done_to_bypass = q.done_byp;
endmodule

// File: rtl/flash_read_port_chk.sv
module flash_read_port_chk
    import flash_read_port_pkg::*;
#(
    parameter int unsigned IDX_SHIFT = 1,
    parameter int unsigned CFI_DEPTH = 82
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_en,
    input logic [7:0]  addr_lo,
    input logic [2:0]  mode,
    input logic [31:0] rdata,
    input logic        prog_go,
    input logic        prog_msb,
    input logic        chip_erase_go,
    input logic        sector_erase_go,
    input logic        tmr_expire,
    input logic        erase_done,
    input logic        done_to_bypass,
    input logic [7:0]  status_now
);
    logic armed_q;
    logic [7:0] idx;
    assign idx = addr_lo >> IDX_SHIFT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R2
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !rd_en) |=> $stable(rdata));

    // R5
    status_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && rd_en && mode == MODE_STATUS && !prog_go && !chip_erase_go
         && !sector_erase_go && !tmr_expire)
        |=> status_now == ($past(status_now) ^ 8'h40));

    // R6
    prog_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && prog_go && !chip_erase_go && !sector_erase_go)
        |=> status_now == ($past(prog_msb) ? 8'h7F : 8'hFF));

    // R7
    erase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_erase_go || sector_erase_go) |=> status_now == 8'h00);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_done |=> !erase_done);

    // R8
    done_byp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_to_bypass |-> erase_done);

    // R9
    cfi_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mode == MODE_CFI && 32'(idx) >= CFI_DEPTH) |=> rdata == 32'h0);
endmodule

bind flash_read_port flash_read_port_chk #(
    .IDX_SHIFT (IDX_SHIFT),
    .CFI_DEPTH (CFI_DEPTH)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .rd_en           (rd_en),
    .addr_lo         (addr[7:0]),
    .mode            (mode),
    .rdata           (rdata),
    .prog_go         (prog_go),
    .prog_msb        (prog_msb),
    .chip_erase_go   (chip_erase_go),
    .sector_erase_go (sector_erase_go),
    .tmr_expire      (tmr_expire),
    .erase_done      (erase_done),
    .done_to_bypass  (done_to_bypass),
    .status_now      (status_now)
);

// File: tb/flash_read_port_bench.sv
module flash_read_port_bench;
    localparam int unsigned AW     = 16;
    localparam int unsigned CHIP   = 20;
    localparam int unsigned SECT   = 7;
    localparam int unsigned DEPTH  = 82;
    localparam logic [15:0] I0 = 16'h0001;
    localparam logic [15:0] I1 = 16'h227E;
    localparam logic [15:0] I2 = 16'h2210;
    localparam logic [15:0] I3 = 16'h12FF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [1:0]    acc_size = 2'd0;
    logic          big_endian = 1'b0;
    logic [2:0]    mode = 3'd0;
    logic          bypass = 1'b0;
    logic [31:0]   arr_bytes;
    logic [7:0]    cfi_index;
    logic [7:0]    cfi_byte;
    logic          prog_go = 1'b0;
    logic          prog_msb = 1'b0;
    logic          chip_erase_go = 1'b0;
    logic          sector_erase_go = 1'b0;
    logic [31:0]   rdata;
    logic          erase_done;
    logic          done_to_bypass;

    int checks = 0;
    int errors = 0;
    logic [7:0] st = 8'h00;

    always #4 clk = ~clk;

    function automatic logic [7:0] mem(input logic [AW-1:0] a);
        return 8'((a * 37) + 11);
    endfunction

    assign arr_bytes = {mem(addr + 3), mem(addr + 2), mem(addr + 1), mem(addr)};
    assign cfi_byte  = cfi_index ^ 8'h5A;

    function automatic logic [31:0] exp_arr(input logic [AW-1:0] a, input logic [1:0] sz,
                                            input logic be);
        logic [7:0] b0, b1, b2, b3;
        b0 = mem(a); b1 = mem(a + 1); b2 = mem(a + 2); b3 = mem(a + 3);
        case (sz)
            2'd1:    return be ? {16'h0, b0, b1} : {16'h0, b1, b0};
            2'd2:    return be ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
            default: return {24'h0, b0};
        endcase
    endfunction

    flash_read_port #(
        .ADDR_W (AW), .DEV_BYTES (2),
        .ID0 (I0), .ID1 (I1), .ID2 (I2), .ID3 (I3),
        .CFI_DEPTH (DEPTH), .CHIP_CYCLES (CHIP), .SECTOR_CYCLES (SECT)
    ) u_flash_read_port (
        .clk (clk), .rst_n (rst_n), .rd_en (rd_en), .addr (addr),
        .acc_size (acc_size), .big_endian (big_endian), .mode (mode),
        .bypass (bypass), .arr_bytes (arr_bytes), .cfi_index (cfi_index),
        .cfi_byte (cfi_byte), .prog_go (prog_go), .prog_msb (prog_msb),
        .chip_erase_go (chip_erase_go), .sector_erase_go (sector_erase_go),
        .rdata (rdata), .erase_done (erase_done), .done_to_bypass (done_to_bypass)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [1:0] sz,
                           input logic be, input logic [2:0] md);
        addr = a; acc_size = sz; big_endian = be; mode = md; rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic read_status(input string req);
        do_read(16'h0, 2'd0, 1'b0, 3'd3);
        check(rdata, {24'h0, st}, req);
        st = st ^ 8'h40;
    endtask

    task automatic wait_done(input int dur, input logic byp, input int already);
        for (int i = already + 1; i < dur; i++) begin
            tick();
            check({31'h0, erase_done}, 32'h0, "R8 early");
        end
        tick();
        check({31'h0, erase_done}, 32'h1, "R8 expiry");
        check({31'h0, done_to_bypass}, {31'h0, byp}, "R8 bypass flag");
        st = st ^ 8'h80;
        tick();
        check({31'h0, erase_done}, 32'h0, "R8 single pulse");
    endtask

    initial begin
        logic [7:0] idx;
        logic [31:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(rdata, 32'h0, "R10 rdata");
        check({30'h0, erase_done, done_to_bypass}, 32'h0, "R10 done");
        read_status("R10 status");

        // R1 array modes, sizes and byte orders
        foreach (e[k]) begin end
        for (int m = 0; m < 8; m++) begin
            if (m >= 2 && m <= 4) continue;
            for (int sz = 0; sz < 3; sz++)
                for (int be = 0; be < 2; be++)
                    for (int a = 0; a < 40; a += 13) begin
                        do_read(AW'(a + m * 101), 2'(sz), 1'(be), 3'(m));
                        check(rdata, exp_arr(AW'(a + m * 101), 2'(sz), 1'(be)), "R1 array");
                    end
        end

        // R2 hold while no read
        e = rdata;
        addr = 16'h0077; mode = 3'd4;
        repeat (4) tick();
        check(rdata, e, "R2 hold");

        // R3 R4 autoselect sweep
        for (int a = 0; a < 256; a++) begin
            idx = 8'(a) >> 1;
            do_read(AW'(a + 16'h0300), 2'd1, 1'b0, 3'd2);
            case (idx)
                8'h00: e = {16'h0, I0};
                8'h01: e = {16'h0, I1};
                8'h02: e = 32'h0;
                8'h0E: e = {16'h0, I2};
                default: e = exp_arr(AW'(a + 16'h0300), 2'd1, 1'b0);
            endcase
            if (idx <= 8'h02) check(rdata, e, "R3 id word");
            else              check(rdata, e, "R4 id fallback");
        end

        // R9 CFI sweep
        for (int a = 0; a < 256; a++) begin
            idx = 8'(a) >> 1;
            do_read(AW'(a), 2'd0, 1'b0, 3'd4);
            e = (idx < DEPTH) ? {24'h0, idx ^ 8'h5A} : 32'h0;
            check(rdata, e, "R9 cfi");
        end

        // R5 R6 status and program
        read_status("R5 toggle a");
        read_status("R5 toggle b");
        prog_msb = 1'b1; prog_go = 1'b1; tick(); prog_go = 1'b0;
        st = 8'h7F;
        read_status("R6 msb one");
        prog_msb = 1'b0; prog_go = 1'b1; tick(); prog_go = 1'b0;
        st = 8'hFF;
        read_status("R6 msb zero");
        read_status("R5 toggle c");

        // R7 R8 chip erase, bypass low
        bypass = 1'b0;
        chip_erase_go = 1'b1; tick(); chip_erase_go = 1'b0;
        st = 8'h00;
        wait_done(CHIP, 1'b0, 0);
        read_status("R8 bit7 after chip");

        // R7 R8 sector erase with reads while busy, bypass high
        bypass = 1'b1;
        sector_erase_go = 1'b1; tick(); sector_erase_go = 1'b0;
        st = 8'h00;
        read_status("R7 busy read 1");
        read_status("R7 busy read 2");
        wait_done(SECT, 1'b1, 2);
        read_status("R8 bit7 after sector");

        // R7 restart reloads the timer
        bypass = 1'b0;
        sector_erase_go = 1'b1; tick(); sector_erase_go = 1'b0;
        repeat (3) begin
            tick();
            check({31'h0, erase_done}, 32'h0, "R7 before restart");
        end
        prog_msb = 1'b1; prog_go = 1'b1; tick(); prog_go = 1'b0;
        sector_erase_go = 1'b1; tick(); sector_erase_go = 1'b0;
        st = 8'h00;
        wait_done(SECT, 1'b0, 0);
        read_status("R7 status after restart");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule